// File: doc/BRIEF.md
# Byte-wide GPIO port with edge interrupts

This block is an eight-pin general-purpose I/O port sitting on a simple byte-wide peripheral bus. Software reads and writes a small set of byte registers: the current pin levels, output values, directions, interrupt flags, edge polarities, interrupt enables, a two-bit function select per pin and a pull-resistor enable. From these the port drives a per-pin output enable and output value, and a pull enable with a pull direction, to the pad ring.

Each pin either acts as plain I/O or hands its output value to a primary or a secondary peripheral function. Pins in plain I/O mode (and the reserved mode) can raise interrupts: a programmable rising or falling edge on the synchronised pin input sets the pin's flag, and one combined request goes out when any enabled pin holds a flag. Flags can be written by software to clear or force them. Two resets exist: `rst_n` is the asynchronous hard reset that clears all state, and `puc` is a synchronous power-up clear that clears every control register except the edge-polarity register.

Top module: `gpio_port`

## Requirements
- R1: After `rst_n` is released, `pin_oe`, `pull_en`, `pull_up` and `irq` are 0 and every register reads back 0.
- R2: Byte addresses are output 0x21, direction 0x22, flag 0x23, edge polarity 0x24, interrupt enable 0x25, function select low bit 0x26, pull enable 0x27 and function select high bit 0x41; a write with `bus_we` high updates the register at the next rising clock and `bus_rdata` returns it combinationally; any other address reads 0.
- R3: Address 0x20 reads the current `pin_in` levels; writes to it change nothing.
- R4: `pin_oe` bit i equals direction bit i (1 = output) in every function mode.
- R5: With the select pair {high bit, low bit} of a pin at 01, `pin_out` carries `pri_val`; at 11 it carries `sec_val`; at 00 or 10 it carries the output register bit.
- R6: A pin whose edge-polarity bit is 0 sets its flag on a low-to-high change of `pin_in` between two consecutive clock samples; with the bit at 1 it sets on a high-to-low change. The flag is visible from the clock edge that samples the new level.
- R7: A pin whose select low bit is 1 never sets its flag and never contributes to `irq`.
- R8: `irq` is 1 exactly when some pin has enable bit 1, flag bit 1 and select low bit 0.
- R9: Writing the flag register sets and clears flags bit by bit; an edge detected in the same cycle as a write of 0 leaves that flag at 1.
- R10: A cycle with `puc` high clears output, direction, flag, enable, both select and pull-enable registers and leaves the edge-polarity register unchanged; `puc` takes priority over a bus write.
- R11: `pull_en` bit i is 1 only when pull enable is 1 and direction is 0; `pull_up` bit i is 1 when `pull_en` is 1 and the output bit is 1.
- R12: The first clock sample after `rst_n` release never produces an edge, whatever level `pin_in` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| puc | input | 1 | Synchronous power-up clear |
| bus_we | input | 1 | Byte write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pin_in | input | NPINS | Synchronised pin levels |
| pri_val | input | NPINS | Primary peripheral output values |
| sec_val | input | NPINS | Secondary peripheral output values |
| pin_oe | output | NPINS | Per-pin output enable |
| pin_out | output | NPINS | Per-pin output value |
| pull_en | output | NPINS | Pull resistor enable |
| pull_up | output | NPINS | Pull direction, 1 = up |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the port with its defaults, NPINS = 8 and ADDR_W = 8, so every bit of every byte register maps to a real pin and the full address space, including unmapped holes, is reachable. With eight pins each check mixes several pins in different modes in one byte, so all four select codes and both edge polarities are exercised side by side in a single access, along with the collision of a flag write and a detected edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    FN_IO  = 2'b00,
    FN_PRI = 2'b01,
    FN_RSV = 2'b10,
    FN_SEC = 2'b11
  } pin_fn_e;

  // True when the sampled pair shows the transition the polarity bit asks for.
  function automatic logic edge_seen(logic prev, logic cur, logic falling);
    return falling ? (prev & ~cur) : (~prev & cur);
  endfunction

  // Value a pin drives for its function mode.
  function automatic logic fn_drive(pin_fn_e fn, logic gpio_v, logic pri_v, logic sec_v);
    case (fn)
      FN_PRI:  return pri_v;
      FN_SEC:  return sec_v;
      default: return gpio_v;
    endcase
  endfunction
endpackage

// File: rtl/gpio_edge.sv
module gpio_edge #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_in,
  input  logic [N-1:0] falling,
  input  logic [N-1:0] blocked,
  output logic [N-1:0] hit,
  output logic         armed
);
  import gpio_pkg::*;

  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      armed  <= 1'b0;
    end else begin
      prev_q <= pin_in;
      armed  <= 1'b1;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    assign hit[i] = armed & ~blocked[i] & edge_seen(prev_q[i], pin_in[i], falling[i]);
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int N      = 8,
  parameter int AW     = 8,
  parameter logic [AW-1:0] A_IN   = 'h20,
  parameter logic [AW-1:0] A_OUT  = 'h21,
  parameter logic [AW-1:0] A_DIR  = 'h22,
  parameter logic [AW-1:0] A_FLAG = 'h23,
  parameter logic [AW-1:0] A_POL  = 'h24,
  parameter logic [AW-1:0] A_IEN  = 'h25,
  parameter logic [AW-1:0] A_FSL  = 'h26,
  parameter logic [AW-1:0] A_PUL  = 'h27,
  parameter logic [AW-1:0] A_FSH  = 'h41
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          puc,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic [N-1:0]  pin_in,
  input  logic [N-1:0]  edge_hit,
  output logic [7:0]    rdata,
  output logic [N-1:0]  out_q,
  output logic [N-1:0]  dir_q,
  output logic [N-1:0]  ifg_q,
  output logic [N-1:0]  pol_q,
  output logic [N-1:0]  ien_q,
  output logic [N-1:0]  fsl_q,
  output logic [N-1:0]  fsh_q,
  output logic [N-1:0]  pul_q
);
  logic [N-1:0] wd;
  logic wr_out, wr_dir, wr_flag, wr_pol, wr_ien, wr_fsl, wr_fsh, wr_pul;

  assign wd      = wdata[N-1:0];
  assign wr_out  = we && (addr == A_OUT);
  assign wr_dir  = we && (addr == A_DIR);
  assign wr_flag = we && (addr == A_FLAG);
  assign wr_pol  = we && (addr == A_POL);
  assign wr_ien  = we && (addr == A_IEN);
  assign wr_fsl  = we && (addr == A_FSL);
  assign wr_fsh  = we && (addr == A_FSH);
  assign wr_pul  = we && (addr == A_PUL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0; dir_q <= '0; ifg_q <= '0; pol_q <= '0;
      ien_q <= '0; fsl_q <= '0; fsh_q <= '0; pul_q <= '0;
    end else if (puc) begin
      out_q <= '0; dir_q <= '0; ifg_q <= '0;
      ien_q <= '0; fsl_q <= '0; fsh_q <= '0; pul_q <= '0;
    end else begin
      if (wr_out) out_q <= wd;
      if (wr_dir) dir_q <= wd;
      if (wr_pol) pol_q <= wd;
      if (wr_ien) ien_q <= wd;
      if (wr_fsl) fsl_q <= wd;
      if (wr_fsh) fsh_q <= wd;
      if (wr_pul) pul_q <= wd;
      ifg_q <= (wr_flag ? wd : ifg_q) | edge_hit;
    end
  end

  always_comb begin
    rdata = '0;
    if      (addr == A_IN)   rdata[N-1:0] = pin_in;
    else if (addr == A_OUT)  rdata[N-1:0] = out_q;
    else if (addr == A_DIR)  rdata[N-1:0] = dir_q;
    else if (addr == A_FLAG) rdata[N-1:0] = ifg_q;
    else if (addr == A_POL)  rdata[N-1:0] = pol_q;
    else if (addr == A_IEN)  rdata[N-1:0] = ien_q;
    else if (addr == A_FSL)  rdata[N-1:0] = fsl_q;
    else if (addr == A_FSH)  rdata[N-1:0] = fsh_q;
    else if (addr == A_PUL)  rdata[N-1:0] = pul_q;
  end
endmodule

// File: rtl/gpio_pad.sv
module gpio_pad #(
  parameter int N = 8
) (
  input  logic [N-1:0] dir,
  input  logic [N-1:0] outv,
  input  logic [N-1:0] fsl,
  input  logic [N-1:0] fsh,
  input  logic [N-1:0] pul,
  input  logic [N-1:0] pri_val,
  input  logic [N-1:0] sec_val,
  output logic [N-1:0] pin_oe,
  output logic [N-1:0] pin_out,
  output logic [N-1:0] pull_en,
  output logic [N-1:0] pull_up
);
  import gpio_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_pin
    pin_fn_e fn;
    assign fn         = pin_fn_e'({fsh[i], fsl[i]});
    assign pin_oe[i]  = dir[i];
    assign pin_out[i] = fn_drive(fn, outv[i], pri_val[i], sec_val[i]);
    assign pull_en[i] = pul[i] & ~dir[i];
    assign pull_up[i] = pul[i] & ~dir[i] & outv[i];
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] A_IN   = 'h20,
  parameter logic [ADDR_W-1:0] A_OUT  = 'h21,
  parameter logic [ADDR_W-1:0] A_DIR  = 'h22,
  parameter logic [ADDR_W-1:0] A_FLAG = 'h23,
  parameter logic [ADDR_W-1:0] A_POL  = 'h24,
  parameter logic [ADDR_W-1:0] A_IEN  = 'h25,
  parameter logic [ADDR_W-1:0] A_FSL  = 'h26,
  parameter logic [ADDR_W-1:0] A_PUL  = 'h27,
  parameter logic [ADDR_W-1:0] A_FSH  = 'h41
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              puc,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  input  logic [NPINS-1:0]  pri_val,
  input  logic [NPINS-1:0]  sec_val,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pull_en,
  output logic [NPINS-1:0]  pull_up,
  output logic              irq
);
  logic [NPINS-1:0] out_q, dir_q, ifg_q, pol_q, ien_q, fsl_q, fsh_q, pul_q;
  logic [NPINS-1:0] edge_hit;
  logic             armed;

  gpio_regs #(
    .N(NPINS), .AW(ADDR_W), .A_IN(A_IN), .A_OUT(A_OUT), .A_DIR(A_DIR),
    .A_FLAG(A_FLAG), .A_POL(A_POL), .A_IEN(A_IEN), .A_FSL(A_FSL),
    .A_PUL(A_PUL), .A_FSH(A_FSH)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .puc(puc), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .pin_in(pin_in), .edge_hit(edge_hit), .rdata(bus_rdata),
    .out_q(out_q), .dir_q(dir_q), .ifg_q(ifg_q), .pol_q(pol_q),
    .ien_q(ien_q), .fsl_q(fsl_q), .fsh_q(fsh_q), .pul_q(pul_q)
  );

  gpio_edge #(.N(NPINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .falling(pol_q),
    .blocked(fsl_q), .hit(edge_hit), .armed(armed)
  );

  gpio_pad #(.N(NPINS)) u_pad (
    .dir(dir_q), .outv(out_q), .fsl(fsl_q), .fsh(fsh_q), .pul(pul_q),
    .pri_val(pri_val), .sec_val(sec_val), .pin_oe(pin_oe), .pin_out(pin_out),
    .pull_en(pull_en), .pull_up(pull_up)
  );

  assign irq = |(ien_q & ifg_q & ~fsl_q);
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int N  = 8,
  parameter int AW = 8,
  parameter logic [AW-1:0] A_FLAG = 'h23
) (
  input logic          clk,
  input logic          rst_n,
  input logic          puc,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          irq,
  input logic [N-1:0]  pin_oe,
  input logic [N-1:0]  dir_q,
  input logic [N-1:0]  ifg_q,
  input logic [N-1:0]  ien_q,
  input logic [N-1:0]  pol_q,
  input logic [N-1:0]  fsl_q,
  input logic [N-1:0]  edge_hit,
  input logic          armed
);
  // R4
  oe_follows_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe == dir_q);

  // R8
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ien_q & ifg_q) == '0) |-> !irq);

  // R6
  edge_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!puc && edge_hit != '0) |=> ((ifg_q & $past(edge_hit)) == $past(edge_hit)));

  // R7
  blocked_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit & fsl_q) == '0);

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!puc && !(bus_we && bus_addr == A_FLAG) && edge_hit == '0) |=> $stable(ifg_q));

  // R10
  puc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    puc |=> (dir_q == '0 && ifg_q == '0 && ien_q == '0 && fsl_q == '0));

  // R10
  puc_keeps_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    puc |=> $stable(pol_q));

  // R12
  unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (edge_hit == '0));
endmodule

bind gpio_port gpio_port_chk #(.N(NPINS), .AW(ADDR_W), .A_FLAG(A_FLAG)) u_chk (
  .clk(clk), .rst_n(rst_n), .puc(puc), .bus_we(bus_we), .bus_addr(bus_addr),
  .irq(irq), .pin_oe(pin_oe), .dir_q(dir_q), .ifg_q(ifg_q), .ien_q(ien_q),
  .pol_q(pol_q), .fsl_q(fsl_q), .edge_hit(edge_hit), .armed(armed)
);

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       puc = 1'b0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = 8'hFF;
  logic [7:0] pri_val = 8'h00;
  logic [7:0] sec_val = 8'h00;
  logic [7:0] pin_oe, pin_out, pull_en, pull_up;
  logic       irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  gpio_port uut (
    .clk(clk), .rst_n(rst_n), .puc(puc), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pri_val(pri_val), .sec_val(sec_val), .pin_oe(pin_oe), .pin_out(pin_out),
    .pull_en(pull_en), .pull_up(pull_up), .irq(irq)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    // R12: pins held high through reset, no edge expected afterwards
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 pin_oe", pin_oe, 8'h00);
    check("R1 pull", pull_en | pull_up, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    rd(8'h21, v); check("R1 out", v, 8'h00);
    rd(8'h41, v); check("R1 fsh", v, 8'h00);
    rd(8'h23, v); check("R12 flag", v, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(8'h22, 8'h5A); rd(8'h22, v); check("R2 dir", v, 8'h5A);
    wr(8'h24, 8'hC3); rd(8'h24, v); check("R2 pol", v, 8'hC3);
    wr(8'h27, 8'h81); rd(8'h27, v); check("R2 pul", v, 8'h81);
    wr(8'h41, 8'h3C); rd(8'h41, v); check("R2 fsh", v, 8'h3C);
    rd(8'h28, v); check("R2 hole", v, 8'h00);
    wr(8'h22, 8'h00); wr(8'h24, 8'h00); wr(8'h27, 8'h00); wr(8'h41, 8'h00);
  endtask

  task automatic t_input();
    logic [7:0] v;
    @(negedge clk) pin_in = 8'hA5;
    rd(8'h20, v); check("R3 in", v, 8'hA5);
    wr(8'h20, 8'h3C);
    rd(8'h20, v); check("R3 write ignored", v, 8'hA5);
    rd(8'h23, v);
    wr(8'h23, 8'h00);
  endtask

  task automatic t_funcsel();
    logic [7:0] e;
    wr(8'h22, 8'hF0);
    #1 check("R4 oe", pin_oe, 8'hF0);
    wr(8'h21, 8'h0F); wr(8'h22, 8'hFF);
    pri_val = 8'hAA; sec_val = 8'h55;
    wr(8'h26, 8'h03); wr(8'h41, 8'h0A);
    for (int i = 0; i < 8; i++) begin
      case ({(i == 1 || i == 3), (i == 0 || i == 1)})
        2'b01:   e[i] = pri_val[i];
        2'b11:   e[i] = sec_val[i];
        default: e[i] = 8'h0F >> i;
      endcase
    end
    #1 check("R5 pin_out", pin_out, e);
    check("R4 oe in fn mode", pin_oe, 8'hFF);
    wr(8'h26, 8'h00); wr(8'h41, 8'h00); wr(8'h22, 8'h00); wr(8'h21, 8'h00);
  endtask

  task automatic t_edges();
    logic [7:0] v;
    wr(8'h24, 8'h0F);
    @(negedge clk) pin_in = 8'h0F;
    @(negedge clk);
    wr(8'h23, 8'h00);
    @(negedge clk) pin_in = 8'hF0;
    rd(8'h23, v); check("R6 both polarities", v, 8'hFF);
    wr(8'h23, 8'h00);
    @(negedge clk) pin_in = 8'h0F;
    rd(8'h23, v); check("R6 wrong direction", v, 8'h00);
    #1 check("R8 irq no enable", {7'd0, irq}, 8'h00);
    wr(8'h23, 8'h10);
    #1 check("R8 irq masked", {7'd0, irq}, 8'h00);
    wr(8'h25, 8'h10);
    #1 check("R8 irq on", {7'd0, irq}, 8'h01);
    wr(8'h26, 8'h10);
    #1 check("R7 irq gated", {7'd0, irq}, 8'h00);
    wr(8'h26, 8'h00); wr(8'h23, 8'h00); wr(8'h25, 8'h00);
  endtask

  task automatic t_selgate();
    logic [7:0] v;
    wr(8'h24, 8'h00);
    @(negedge clk) pin_in = 8'h00;
    @(negedge clk);
    wr(8'h26, 8'h0F); wr(8'h41, 8'hF0);
    @(negedge clk) pin_in = 8'hFF;
    rd(8'h23, v); check("R7 blocked pins", v, 8'hF0);
    wr(8'h26, 8'h00); wr(8'h41, 8'h00); wr(8'h23, 8'h00);
  endtask

  task automatic t_flagwrite();
    logic [7:0] v;
    wr(8'h23, 8'h81);
    rd(8'h23, v); check("R9 force", v, 8'h81);
    @(negedge clk) pin_in = 8'hFF;
    @(negedge clk) pin_in = 8'h00;
    @(negedge clk);
    // R9 collision: rising edge on pin 2 with a write of 0
    bus_we = 1'b1; bus_addr = 8'h23; bus_wdata = 8'h00; pin_in = 8'h04;
    @(negedge clk) bus_we = 1'b0;
    rd(8'h23, v); check("R9 edge wins", v, 8'h04);
    wr(8'h23, 8'h00);
  endtask

  task automatic t_pull();
    wr(8'h27, 8'hFF); wr(8'h22, 8'h0F); wr(8'h21, 8'h33);
    #1 check("R11 pull_en", pull_en, 8'hF0);
    check("R11 pull_up", pull_up, 8'h30);
  endtask

  task automatic t_puc();
    logic [7:0] v;
    wr(8'h24, 8'h96); wr(8'h25, 8'hFF); wr(8'h23, 8'h11); wr(8'h26, 8'h22);
    @(negedge clk);
    puc = 1'b1; bus_we = 1'b1; bus_addr = 8'h24; bus_wdata = 8'h00;
    @(negedge clk);
    puc = 1'b0; bus_we = 1'b0;
    rd(8'h24, v); check("R10 pol kept", v, 8'h96);
    rd(8'h22, v); check("R10 dir", v, 8'h00);
    rd(8'h23, v); check("R10 flag", v, 8'h00);
    rd(8'h27, v); check("R10 pul", v, 8'h00);
    rd(8'h21, v); check("R10 out", v, 8'h00);
    #1 check("R10 irq", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_input();
    t_funcsel();
    t_edges();
    t_selgate();
    t_flagwrite();
    t_pull();
    t_puc();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 8'h00, 8'h01);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule